// File: doc/BRIEF.md
# Four-Channel Converter Register Bank

This block holds the digital codes for four converter channels. A serial front end, not part of this block, assembles 24-bit command words and presents each complete one with a single-cycle execute strobe. The bank decodes the word and changes its state at the next clock edge.

Each channel has two 16-bit registers. The staging register holds a code that is waiting to be used. The output register holds the code the converter shows now. Commands can do any of these:
- load staging registers;
- move staged codes to the outputs;
- do both in one word;
- address one channel or all of them;
- set a per-channel mask that makes a channel's output follow every staging write;
- clear the bank at two depths.

Power-down words are not acted on here. They are passed on as a one-cycle pulse to a separate power controller.

Word fields:

| Bits | Meaning |
|------|---------|
| [23:22] | Ignored |
| [21:19] | Opcode |
| [18:16] | Channel select |
| [15:0] | Payload |

Channel select values 0 to 3 pick one channel. Value 7 picks all four.

Top module: `quad_dac_regbank`

## Requirements
- R1: While rst_n is low, and after its release until the first executed word, all four output codes, the mask and pd_pulse are zero. pd_bits is also zero.
- R2: Opcode 000 (word[21:19]) loads payload word[15:0] into the selected staging register(s). The output register is not changed unless that channel's mask bit is 1.
- R3: Opcode 001 copies each selected channel's staging register into its output register.
- R4: Opcode 010 loads the payload into the selected staging register(s). It then sets all four output registers from the staging values, including the value just written.
- R5: Opcode 011 loads the payload into both the staging register and the output register of each selected channel.
- R6: Select values 0, 1, 2 and 3 (word[18:16]) address channels A, B, C and D. Value 7 addresses all four. For opcodes 000 to 011, values 4 to 6 leave all state unchanged.
- R7: Opcode 110 sets the mask from word[3:0], where bit 0 is channel A. The select field is not used. A masked channel's output register takes the payload whenever opcode 000 writes that channel.
- R8: Opcode 101 with word[0]=0 clears all staging and output registers. The mask is kept and no pulse is produced.
- R9: Opcode 101 with word[0]=1 also clears the mask. It pulses pd_pulse for one cycle with pd_bits = 6'b001111, which is normal mode with all four channels selected.
- R10: Opcode 100 changes no register here. It produces pd_pulse for one cycle with pd_bits = word[5:0]. pd_bits is zero in every cycle without a pulse.
- R11: Opcode 111, and any cycle with exec low, changes no state. Every change appears on the outputs at the clock edge that samples the exec strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | One-cycle strobe marking a complete word |
| word | input | 24 | Command word |
| dac_q | output | 64 | Output codes, channel A in bits [15:0] |
| auto_mask | output | 4 | Per-channel auto-update mask |
| pd_pulse | output | 1 | One-cycle power command pulse |
| pd_bits | output | 6 | Mode and channel bits for the power controller |

## Verification
The assertions assume that `word` is meaningful only in cycles where `exec` is high. They also assume that `exec` may be high on consecutive cycles, so no property relies on a gap between strobes.

The stimulus runs in two parts:
- A directed part covers each opcode, the broadcast select, the unused selects, and both reset depths.
- A random part issues words with every opcode and select value. Idle cycles are mixed in, and so are back-to-back strobes.

A behavioural model tracks the expected state and is compared against the outputs on every cycle.

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter int CH = 4,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec,
  input  logic [23:0]      word,
  output logic [CH*DW-1:0] dac_q,
  output logic [CH-1:0]    auto_mask,
  output logic             pd_pulse,
  output logic [5:0]       pd_bits
);
  localparam logic [2:0] OP_WR  = 3'b000;
  localparam logic [2:0] OP_UPD = 3'b001;
  localparam logic [2:0] OP_WRA = 3'b010;
  localparam logic [2:0] OP_WRU = 3'b011;
  localparam logic [2:0] OP_PWR = 3'b100;
  localparam logic [2:0] OP_CLR = 3'b101;
  localparam logic [2:0] OP_MSK = 3'b110;
  localparam logic [2:0] SEL_ALL = 3'b111;

  wire [2:0]    op   = word[21:19];
  wire [2:0]    sel  = word[18:16];
  wire [DW-1:0] data = word[DW-1:0];
  wire          sel_ok = (sel == SEL_ALL) || (int'(sel) < CH);

  genvar g;
  generate
    for (g = 0; g < CH; g++) begin : g_ch
      logic [DW-1:0] stage_r, out_r;
      wire hit = sel_ok && ((sel == SEL_ALL) || (int'(sel) == g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_r <= '0;
          out_r   <= '0;
        end else if (exec) begin
          unique case (op)
            OP_WR: if (hit) begin
              stage_r <= data;
              if (auto_mask[g]) out_r <= data;
            end
            OP_UPD: if (hit) out_r <= stage_r;
            OP_WRA: if (sel_ok) begin
              if (hit) stage_r <= data;
              out_r <= hit ? data : stage_r;
            end
            OP_WRU: if (hit) begin
              stage_r <= data;
              out_r   <= data;
            end
            OP_CLR: begin
              stage_r <= '0;
              out_r   <= '0;
            end
            default: ;
          endcase
        end
      end

      assign dac_q[g*DW +: DW] = out_r;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_mask <= '0;
      pd_pulse  <= 1'b0;
      pd_bits   <= '0;
    end else begin
      pd_pulse <= 1'b0;
      pd_bits  <= '0;
      if (exec) begin
        if (op == OP_MSK) auto_mask <= data[CH-1:0];
        if (op == OP_PWR) begin
          pd_pulse <= 1'b1;
          pd_bits  <= word[5:0];
        end
        if (op == OP_CLR && word[0]) begin
          auto_mask <= '0;
          pd_pulse  <= 1'b1;
          pd_bits   <= 6'b001111;
        end
      end
    end
  end
endmodule

module quad_dac_regbank_chk #(
  parameter int CH = 4,
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exec,
  input logic [23:0]      word,
  input logic [CH*DW-1:0] dac_q,
  input logic [CH-1:0]    auto_mask,
  input logic             pd_pulse,
  input logic [5:0]       pd_bits
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(dac_q) && $stable(auto_mask) && !pd_pulse)); // R11
  AST_OP7_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:19] == 3'b111) |=> ($stable(dac_q) && $stable(auto_mask))); // R11
  AST_PWR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:19] == 3'b100) |=> (pd_pulse && pd_bits == $past(word[5:0]) && $stable(dac_q))); // R10
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:19] == 3'b101) |=> (dac_q == '0)); // R8
  AST_SHALLOW_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:19] == 3'b101 && !word[0]) |=> ($stable(auto_mask) && !pd_pulse)); // R8
  AST_DEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:19] == 3'b101 && word[0]) |=> (auto_mask == '0 && pd_pulse && pd_bits == 6'b001111)); // R9
  AST_WRITE_THROUGH_A: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:16] == 6'b011000) |=> (dac_q[DW-1:0] == $past(word[DW-1:0]))); // R5
  AST_BAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !word[21] && word[18:16] inside {3'd4, 3'd5, 3'd6}) |=> $stable(dac_q)); // R6
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && word[21:19] == 3'b110) |=> (auto_mask == $past(word[CH-1:0]))); // R7
endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(.CH(CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .word(word), .dac_q(dac_q),
  .auto_mask(auto_mask), .pd_pulse(pd_pulse), .pd_bits(pd_bits)
);

// File: tb/quad_dac_regbank_test.sv
`timescale 1ns/1ps
module quad_dac_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [23:0] word = '0;
  logic [63:0] dac_q;
  logic [3:0]  auto_mask;
  logic        pd_pulse;
  logic [5:0]  pd_bits;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_stage [4];
  logic [15:0] m_out [4];
  logic [3:0]  m_mask;
  logic        m_pulse;
  logic [5:0]  m_bits;

  always #2 clk = ~clk;

  quad_dac_regbank uut (
    .clk(clk), .rst_n(rst_n), .exec(exec), .word(word), .dac_q(dac_q),
    .auto_mask(auto_mask), .pd_pulse(pd_pulse), .pd_bits(pd_bits)
  );

  function automatic logic [23:0] mk(input logic [2:0] op, input logic [2:0] sel, input logic [15:0] d);
    return {2'b00, op, sel, d};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_stage[i] = '0;
      m_out[i] = '0;
    end
    m_mask = '0;
    m_pulse = 1'b0;
    m_bits = '0;
  endtask

  task automatic model_step(input logic e, input logic [23:0] w);
    logic [2:0] op = w[21:19];
    logic [2:0] sel = w[18:16];
    bit ok = (sel == 3'd7) || (sel < 3'd4);
    m_pulse = 1'b0;
    m_bits = '0;
    if (!e) return;
    for (int i = 0; i < 4; i++) begin
      bit hit = ok && (sel == 3'd7 || sel == 3'(i));
      case (op)
        3'd0: if (hit) begin m_stage[i] = w[15:0]; if (m_mask[i]) m_out[i] = w[15:0]; end
        3'd1: if (hit) m_out[i] = m_stage[i];
        3'd2: if (hit) m_stage[i] = w[15:0];
        3'd3: if (hit) begin m_stage[i] = w[15:0]; m_out[i] = w[15:0]; end
        3'd5: begin m_stage[i] = '0; m_out[i] = '0; end
        default: ;
      endcase
    end
    if (op == 3'd2 && ok)
      for (int i = 0; i < 4; i++) m_out[i] = m_stage[i];
    if (op == 3'd6) m_mask = w[3:0];
    if (op == 3'd4) begin m_pulse = 1'b1; m_bits = w[5:0]; end
    if (op == 3'd5 && w[0]) begin m_mask = '0; m_pulse = 1'b1; m_bits = 6'b001111; end
  endtask

  task automatic compare(input string tag);
    checks++;
    for (int i = 0; i < 4; i++)
      if (dac_q[i*16 +: 16] !== m_out[i]) begin
        failures++;
        $display("FAIL %s: channel %0d code actual=%h expected=%h", tag, i, dac_q[i*16 +: 16], m_out[i]);
      end
    if (auto_mask !== m_mask) begin
      failures++;
      $display("FAIL %s: mask actual=%b expected=%b", tag, auto_mask, m_mask);
    end
    if (pd_pulse !== m_pulse || pd_bits !== m_bits) begin
      failures++;
      $display("FAIL %s: pd actual=%b/%b expected=%b/%b", tag, pd_pulse, pd_bits, m_pulse, m_bits);
    end
  endtask

  task automatic cyc(input logic e, input logic [23:0] w, input string tag);
    exec = e;
    word = w;
    model_step(e, w);
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    @(negedge clk);
    #1 compare("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 24'hFFFFFF, "R1 after release");
    cyc(1'b1, mk(3'd0, 3'd0, 16'h1234), "R2 stage A only");
    cyc(1'b0, 24'h0, "R11 idle");
    cyc(1'b1, mk(3'd1, 3'd0, 16'hDEAD), "R3 update A");
    cyc(1'b1, mk(3'd0, 3'd2, 16'h5555), "R2 stage C");
    cyc(1'b1, mk(3'd2, 3'd1, 16'hABCD), "R4 write B update all");
    cyc(1'b1, mk(3'd3, 3'd3, 16'hFFFF), "R5 write-through D");
    cyc(1'b1, mk(3'd3, 3'd7, 16'h0F0F), "R6 broadcast write-through");
    cyc(1'b1, mk(3'd3, 3'd5, 16'h7777), "R6 unused select ignored");
    cyc(1'b1, mk(3'd2, 3'd4, 16'h7777), "R6 unused select op010 ignored");
    cyc(1'b1, {2'b11, 3'd0, 3'd6, 16'h7777}, "R6 unused select op000 ignored");
    cyc(1'b1, mk(3'd6, 3'd0, 16'h0005), "R7 mask load");
    cyc(1'b1, mk(3'd0, 3'd7, 16'h2222), "R7 auto update on A and C");
    cyc(1'b1, mk(3'd7, 3'd7, 16'h9999), "R11 op111 ignored");
    cyc(1'b1, mk(3'd4, 3'd0, 16'h002A), "R10 power forward");
    cyc(1'b1, mk(3'd4, 3'd7, 16'hFFFF), "R10 back-to-back pulse");
    cyc(1'b0, 24'h0, "R10 pulse ends");
    cyc(1'b1, mk(3'd5, 3'd0, 16'hFFFE), "R8 shallow clear");
    cyc(1'b1, mk(3'd3, 3'd1, 16'h4321), "R5 write after clear");
    cyc(1'b1, mk(3'd5, 3'd2, 16'h0001), "R9 deep clear");
    cyc(1'b0, 24'h0, "R9 pulse one cycle");
    cyc(1'b1, mk(3'd0, 3'd0, 16'h3333), "R9 mask cleared stage only");
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] w = 24'($urandom);
      logic e = ($urandom % 4) != 0;
      if (w[21:19] == 3'd5 && ($urandom % 4) != 0) w[21:19] = 3'd0;
      cyc(e, w, "R2 R3 R4 R5 R6 R7 R11 random");
    end
    rst_n = 1'b0;
    model_reset();
    @(posedge clk);
    #1 compare("R1 reset again");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule